// File: doc/BRIEF.md
# Colour Palette Lookup Pipeline

This block is the digital front end of an indexed-colour video output. On every pixel clock it takes one pixel index and looks it up in a 256-entry red/green/blue colour table. It then drives three registered channel codes toward external digital-to-analog converters. A per-pixel mode can send a 24-bit direct colour word around the table instead. Another per-pixel mode packs 6-bit table components into the top of each 8-bit channel. A blank input forces black.

A host loads the table through a narrow write port. An address strobe picks the starting entry. The host then sends data strobes carrying red, green and blue, in that order. The three components collect in a staging register, and the whole entry goes into the table in one cycle on the blue strobe. The entry pointer then steps on by itself. The table has a separate read port, so pixel scanout never waits on host traffic.

Top module: `pal_lut_pipe`

## Requirements
- R1: While reset is high, and until the first pixel sampled after reset reaches the outputs, all three channel outputs are zero.
- R2: A pixel sampled at clock edge n appears on the outputs just after edge n+4. Edges n+1 to n+3 are pipeline stages.
- R3: With direct mode and narrow mode both low, the outputs are the red, green and blue components stored at table entry `pix_idx`.
- R4: With narrow mode high and direct mode low, each output channel is the low 6 bits of the stored component, shifted into bits 7:2, with bits 1:0 zero.
- R5: With direct mode high, red = `pix_direct[23:16]`, green = `pix_direct[15:8]` and blue = `pix_direct[7:0]`. The table is not read, and narrow mode has no effect.
- R6: A pixel sampled with `pix_blank` high produces zero on all three outputs, whatever the modes.
- R7: Data strobes are taken as red, then green, then blue. The blue strobe writes all three into the entry at the pointer, and the pointer then moves up by one.
- R8: The entry pointer wraps from 255 to 0.
- R9: An address strobe loads the pointer from `host_wdata` and makes the next data strobe count as red. When an address strobe and a data strobe arrive in the same cycle, the address strobe wins and the data is dropped.
- R10: After only a red strobe, or a red and a green strobe, scanout of that entry still shows its old colour.
- R11: Host writes never stall scanout. A pixel read of an entry at the same edge as its commit returns the old colour, and a read at the next edge returns the new colour.
- R12: Blank and both mode inputs are sampled with the pixel and apply to that pixel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_idx | input | 8 | Pixel index into the colour table |
| pix_direct | input | 24 | Direct colour word: red 23:16, green 15:8, blue 7:0 |
| pix_blank | input | 1 | Forces this pixel to black |
| mode_direct | input | 1 | This pixel takes the direct colour word, not the table |
| mode_narrow | input | 1 | This pixel uses 6-bit table components |
| host_addr_wr | input | 1 | Load the entry pointer from host_wdata |
| host_data_wr | input | 1 | Component write strobe |
| host_wdata | input | 8 | Host address or component value |
| dac_red | output | 8 | Red channel code |
| dac_grn | output | 8 | Green channel code |
| dac_blu | output | 8 | Blue channel code |

## Verification
The assertions rely on the reset pipeline stages holding a blanked pixel. Because of this, a window that reaches back across reset can only show black. The direct-path latency check is gated by a count of cycles since reset. The narrow-mode check assumes the component width is narrower than the channel. The stimulus changes every input half a cycle away from the sampling edge, and it keeps pixels blanked until every table entry has been written. As a result, no entry is displayed before it has been defined. Host strobes are deliberately made to collide with scanout of the same entry, and with each other.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_IDX_W    = 8;
  localparam int PAL_CH_W     = 8;
  localparam int PAL_NARROW_W = 6;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;
endpackage

// File: rtl/pal_host_load.sv
module pal_host_load
  import pal_pkg::*;
#(
  parameter int IDX_W = PAL_IDX_W,
  parameter int CH_W  = PAL_CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic [CH_W-1:0]   wdata,
  output logic              we,
  output logic [IDX_W-1:0]  waddr,
  output logic [3*CH_W-1:0] wword
);
  comp_e           cnt;
  logic [IDX_W-1:0] ptr;
  logic [CH_W-1:0]  hold_r, hold_g;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= COMP_RED;
      ptr    <= '0;
      hold_r <= '0;
      hold_g <= '0;
    end else if (addr_wr) begin
      ptr <= IDX_W'(wdata);
      cnt <= COMP_RED;
    end else if (data_wr) begin
      unique case (cnt)
        COMP_RED: begin hold_r <= wdata; cnt <= COMP_GRN; end
        COMP_GRN: begin hold_g <= wdata; cnt <= COMP_BLU; end
        COMP_BLU: begin cnt <= COMP_RED; ptr <= ptr + IDX_W'(1); end
        default:  cnt <= COMP_RED;
      endcase
    end
  end

  assign we    = data_wr && !addr_wr && (cnt == COMP_BLU);
  assign waddr = ptr;
  assign wword = {hold_r, hold_g, wdata};

  p_cnt_legal_r7: assert property (@(posedge clk) disable iff (rst)
    cnt != comp_e'(2'd3));
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> (ptr == $past(ptr) + IDX_W'(1)) && (cnt == COMP_RED));
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (cnt == COMP_RED) && (ptr == $past(IDX_W'(wdata))));
endmodule

// File: rtl/pal_dpram.sv
module pal_dpram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd <= mem[ra];
  end
endmodule

// File: rtl/pal_fmt.sv
module pal_fmt #(
  parameter int CH_W     = 8,
  parameter int NARROW_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3*CH_W-1:0] lut_q,
  input  logic [3*CH_W-1:0] direct,
  input  logic              sel_direct,
  input  logic              narrow,
  input  logic              blank_in,
  output logic [3*CH_W-1:0] col,
  output logic              blank_out
);
  localparam int PAD_W = CH_W - NARROW_W;

  always_ff @(posedge clk) begin
    if (rst) blank_out <= 1'b1;
    else     blank_out <= blank_in;
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CH_W-1:0] lut_c, pick, col_c;
    assign lut_c = lut_q[c*CH_W +: CH_W];

    always_comb begin
      if (sel_direct)  pick = direct[c*CH_W +: CH_W];
      else if (narrow) pick = {lut_c[NARROW_W-1:0], {PAD_W{1'b0}}};
      else             pick = lut_c;
    end

    always_ff @(posedge clk) begin
      if (rst) col_c <= '0;
      else     col_c <= pick;
    end

    assign col[c*CH_W +: CH_W] = col_c;

    p_narrow_pad_r4: assert property (@(posedge clk) disable iff (rst)
      (narrow && !sel_direct) |=> (col[c*CH_W +: PAD_W] == '0));
  end
endmodule

// File: rtl/pal_lut_pipe.sv
module pal_lut_pipe
  import pal_pkg::*;
#(
  parameter int IDX_W    = PAL_IDX_W,
  parameter int CH_W     = PAL_CH_W,
  parameter int NARROW_W = PAL_NARROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic [3*CH_W-1:0] pix_direct,
  input  logic              pix_blank,
  input  logic              mode_direct,
  input  logic              mode_narrow,
  input  logic              host_addr_wr,
  input  logic              host_data_wr,
  input  logic [CH_W-1:0]   host_wdata,
  output logic [CH_W-1:0]   dac_red,
  output logic [CH_W-1:0]   dac_grn,
  output logic [CH_W-1:0]   dac_blu
);
  localparam int WORD_W = 3 * CH_W;

  // stage 1: capture
  logic [IDX_W-1:0]  s1_idx;
  logic [WORD_W-1:0] s1_dir;
  logic              s1_blank, s1_dmode, s1_nmode;
  // stage 2: table read
  logic [WORD_W-1:0] s2_lut, s2_dir;
  logic              s2_blank, s2_dmode, s2_nmode;
  // stage 3: source select
  logic [WORD_W-1:0] s3_col;
  logic              s3_blank;
  // stage 4: blank gate, stage 5: output
  logic [WORD_W-1:0] s4_col, out_col;

  logic              tb_we;
  logic [IDX_W-1:0]  tb_wa;
  logic [WORD_W-1:0] tb_wd;

  pal_host_load #(.IDX_W(IDX_W), .CH_W(CH_W)) u_load (
    .clk(clk), .rst(rst),
    .addr_wr(host_addr_wr), .data_wr(host_data_wr), .wdata(host_wdata),
    .we(tb_we), .waddr(tb_wa), .wword(tb_wd)
  );

  pal_dpram #(.AW(IDX_W), .DW(WORD_W)) u_table (
    .clk(clk), .we(tb_we), .wa(tb_wa), .wd(tb_wd),
    .ra(s1_idx), .rd(s2_lut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_idx   <= '0;
      s1_dir   <= '0;
      s1_blank <= 1'b1;
      s1_dmode <= 1'b0;
      s1_nmode <= 1'b0;
    end else begin
      s1_idx   <= pix_idx;
      s1_dir   <= pix_direct;
      s1_blank <= pix_blank;
      s1_dmode <= mode_direct;
      s1_nmode <= mode_narrow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_dir   <= '0;
      s2_blank <= 1'b1;
      s2_dmode <= 1'b0;
      s2_nmode <= 1'b0;
    end else begin
      s2_dir   <= s1_dir;
      s2_blank <= s1_blank;
      s2_dmode <= s1_dmode;
      s2_nmode <= s1_nmode;
    end
  end

  pal_fmt #(.CH_W(CH_W), .NARROW_W(NARROW_W)) u_fmt (
    .clk(clk), .rst(rst),
    .lut_q(s2_lut), .direct(s2_dir),
    .sel_direct(s2_dmode), .narrow(s2_nmode), .blank_in(s2_blank),
    .col(s3_col), .blank_out(s3_blank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_col  <= '0;
      out_col <= '0;
    end else begin
      s4_col  <= s3_blank ? '0 : s3_col;
      out_col <= s4_col;
    end
  end

  assign dac_red = out_col[2*CH_W +: CH_W];
  assign dac_grn = out_col[CH_W +: CH_W];
  assign dac_blu = out_col[0 +: CH_W];

  // cycles since reset, saturating, for windowed checks
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  p_blank_black_r6: assert property (@(posedge clk) disable iff (rst)
    $past(pix_blank, 5) |-> ({dac_red, dac_grn, dac_blu} == '0));
  p_direct_lat_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(mode_direct && !pix_blank, 5))
      |-> ({dac_red, dac_grn, dac_blu} == $past(pix_direct, 5)));
endmodule

// File: tb/pal_lut_pipe_test.sv
module pal_lut_pipe_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_direct = '0;
  logic        pix_blank = 1'b1, mode_direct = 1'b0, mode_narrow = 1'b0;
  logic        host_addr_wr = 1'b0, host_data_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  dac_red, dac_grn, dac_blu;

  int    total = 0, bad = 0;
  string phase = "R1";
  bit    seen_edge = 0;
  bit    done = 0;

  always #5 clk = ~clk;

  pal_lut_pipe uut (
    .clk(clk), .rst(rst), .pix_idx(pix_idx), .pix_direct(pix_direct),
    .pix_blank(pix_blank), .mode_direct(mode_direct), .mode_narrow(mode_narrow),
    .host_addr_wr(host_addr_wr), .host_data_wr(host_data_wr),
    .host_wdata(host_wdata),
    .dac_red(dac_red), .dac_grn(dac_grn), .dac_blu(dac_blu)
  );

  // behavioural reference
  logic [23:0] tbl [256];
  logic [23:0] pend [$];
  logic [23:0] expv = '0;
  logic [7:0]  m_ptr = '0, m_r = '0, m_g = '0;
  int          m_cnt = 0;
  logic [7:0]  p_idx = '0;
  logic [23:0] p_dir = '0;
  bit          p_bl = 1, p_dm = 0, p_nm = 0;

  function automatic logic [23:0] shrink(input logic [23:0] v);
    return {v[21:16], 2'b00, v[13:8], 2'b00, v[5:0], 2'b00};
  endfunction

  always @(posedge clk) begin
    logic [23:0] rd;
    seen_edge = 1;
    if (rst) begin
      pend.delete();
      expv = '0; m_ptr = '0; m_cnt = 0;
      p_bl = 1; p_dm = 0; p_nm = 0;
    end else begin
      rd = '0;
      if (!p_bl) rd = p_dm ? p_dir : (p_nm ? shrink(tbl[p_idx]) : tbl[p_idx]);
      pend.push_back(rd);
      if (pend.size() == 4) expv = pend.pop_front();
      else expv = '0;
      if (host_addr_wr) begin
        m_ptr = host_wdata; m_cnt = 0;
      end else if (host_data_wr) begin
        if (m_cnt == 0) begin m_r = host_wdata; m_cnt = 1; end
        else if (m_cnt == 1) begin m_g = host_wdata; m_cnt = 2; end
        else begin
          tbl[m_ptr] = {m_r, m_g, host_wdata};
          m_ptr = m_ptr + 8'd1; m_cnt = 0;
        end
      end
      p_idx = pix_idx; p_dir = pix_direct;
      p_bl = pix_blank; p_dm = mode_direct; p_nm = mode_narrow;
    end
  end

  always @(negedge clk) begin
    if (seen_edge && !done) begin
      total++;
      if ({dac_red, dac_grn, dac_blu} !== expv) begin
        bad++;
        $display("FAIL %s: got %h expected %h", phase,
                 {dac_red, dac_grn, dac_blu}, expv);
      end
    end
  end

  task automatic step(input logic [7:0] idx, input logic [23:0] d,
                      input bit bl, input bit dm, input bit nm,
                      input bit aw, input bit dw, input logic [7:0] hd);
    @(negedge clk);
    pix_idx = idx; pix_direct = d; pix_blank = bl;
    mode_direct = dm; mode_narrow = nm;
    host_addr_wr = aw; host_data_wr = dw; host_wdata = hd;
  endtask

  task automatic pix(input logic [7:0] idx, input bit nm);
    step(idx, 24'h0, 0, 0, nm, 0, 0, 8'h0);
  endtask

  int seed = 32'h1234;
  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h00ffffff;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) tbl[i] = '0;
    repeat (4) @(negedge clk);        // R1: outputs zero under reset
    rst = 1'b0;
    step(0, 0, 1, 0, 0, 0, 0, 0);     // R1: zero after release while blanked

    phase = "R7";                     // full table load, blanked
    step(0, 0, 1, 0, 0, 1, 0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      step(0, 0, 1, 0, 0, 0, 1, 8'(i));
      step(0, 0, 1, 0, 0, 0, 1, 8'(i * 7 + 3));
      step(0, 0, 1, 0, 0, 0, 1, ~8'(i));
    end
    phase = "R8";                     // pointer wrapped to entry 0
    step(0, 0, 1, 0, 0, 0, 1, 8'hAA);
    step(0, 0, 1, 0, 0, 0, 1, 8'hBB);
    step(0, 0, 1, 0, 0, 0, 1, 8'hCC);
    pix(0, 0); pix(1, 0);

    phase = "R3";
    for (int i = 0; i < 256; i++) pix(8'(255 - i), 0);

    phase = "R2";                     // isolated pixel between blanks
    repeat (6) step(0, 0, 1, 0, 0, 0, 0, 0);
    pix(5, 0);
    repeat (6) step(0, 0, 1, 0, 0, 0, 0, 0);

    phase = "R4";
    for (int i = 0; i < 64; i++) pix(8'(i * 3), 1);

    phase = "R5";
    for (int i = 0; i < 32; i++)
      step(8'(i), 24'(rnd()), 0, 1, i[0], 0, 0, 0);

    phase = "R6";
    for (int i = 0; i < 64; i++) begin
      int r = rnd();
      step(8'(r), 24'(rnd()), r[9], r[10], r[11], 0, 0, 0);
    end

    phase = "R12";
    for (int i = 0; i < 48; i++)
      step(8'(i + 17), 24'(rnd()), (i % 5) == 0, i[0], i[1], 0, 0, 0);

    phase = "R10";                    // partial entry stays old during scan
    step(9, 0, 0, 0, 0, 1, 0, 8'd9);
    step(9, 0, 0, 0, 0, 0, 1, 8'h11);
    repeat (3) pix(9, 0);
    step(9, 0, 0, 0, 0, 0, 1, 8'h22);
    repeat (3) pix(9, 0);
    phase = "R11";                    // commit collides with scan of same entry
    step(9, 0, 0, 0, 0, 0, 1, 8'h33);
    repeat (4) pix(9, 0);
    step(10, 0, 0, 0, 1, 0, 1, 8'h44);
    step(10, 0, 0, 0, 1, 0, 1, 8'h55);
    step(10, 0, 0, 0, 0, 0, 1, 8'h66);
    repeat (4) pix(10, 0);

    phase = "R9";                     // restart mid-entry, then simultaneous strobes
    step(20, 0, 0, 0, 0, 1, 0, 8'd20);
    step(20, 0, 0, 0, 0, 0, 1, 8'h01);
    step(30, 0, 0, 0, 0, 0, 1, 8'h02);
    step(30, 0, 0, 0, 0, 1, 0, 8'd30);
    step(20, 0, 0, 0, 0, 0, 1, 8'h03);
    step(30, 0, 0, 0, 0, 0, 1, 8'h04);
    step(20, 0, 0, 0, 0, 0, 1, 8'h05);
    step(40, 0, 0, 0, 0, 1, 1, 8'd40);
    step(40, 0, 0, 0, 0, 0, 1, 8'h06);
    step(31, 0, 0, 0, 0, 0, 1, 8'h07);
    step(40, 0, 0, 0, 0, 0, 1, 8'h08);
    for (int i = 0; i < 12; i++) pix(8'(20 + 10 * (i % 3)), 0);
    pix(31, 0); pix(41, 0);

    phase = "R1";
    repeat (8) step(0, 0, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog in %s: got timeout expected completion", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule